// File: doc/BRIEF.md
# Upward-Growing Byte Stack Pointer

This block keeps the stack pointer for a processor's on-chip data RAM and issues the RAM accesses that push and pop bytes. The stack grows toward higher addresses. A push first advances the pointer and then writes the byte at the new location. A pop first reads the byte at the current location and then steps the pointer back. The pointer comes out of reset at 07H. It wraps modulo 256 and raises no overflow or underflow flag.

Each access moves a single byte. A 16-bit value, such as a return address, is moved as two back-to-back byte accesses, and the block is busy during the second one. A wide push writes the low byte first and the high byte second. A wide pop reads the high byte first and the low byte second, so a wide pop returns exactly what the matching wide push stored.

Software can load the pointer directly. That write wins over any push or pop in the same cycle, including a second byte that is still pending. The RAM sits outside the block and is read combinationally at the address the block drives.

Top module: `upstack`

## Requirements
- R1: After reset, `sp` is 07H, `busy`, `pop_valid` and `ram_we` are 0, and `pop_data` is 0.
- R2: An accepted byte push (`push_req`=1, `wide`=0) drives `ram_we`=1, `ram_addr`=`sp`+1 and `ram_wdata`=`push_data[7:0]` in the request cycle. `sp` holds that address from the next cycle on.
- R3: An accepted byte pop (`pop_req`=1, `wide`=0) drives `ram_addr`=`sp` with `ram_we`=0 in the request cycle. In the next cycle `pop_valid` is 1, `pop_data` is {8'h00, byte read}, and `sp` is one lower.
- R4: An accepted wide push writes `push_data[7:0]` at `sp`+1 in the request cycle. In the next cycle `busy`=1 and it writes `push_data[15:8]` at `sp`+2. `sp` ends two higher.
- R5: An accepted wide pop reads the high byte at `sp` in the request cycle. In the next cycle (`busy`=1) it reads the low byte at `sp`-1. In the cycle after that, `pop_valid`=1 and `pop_data`={high, low}, and `sp` has ended two lower.
- R6: `sp` wraps modulo 256. A push at FFH writes address 00H and leaves `sp`=00H. A pop at 00H leaves `sp`=FFH.
- R7: When `push_req` and `pop_req` are both 1 with `busy`=0 and `sp_we`=0, `conflict_err` is 1 in that cycle. There is no RAM write, `sp` is unchanged, and no `pop_valid` follows.
- R8: When `sp_we`=1, `sp` equals `sp_wdata` in the next cycle. There is no RAM write in that cycle, any push or pop request is dropped, and a pending second byte is cancelled.
- R9: While `busy`=1, new `push_req` and `pop_req` are ignored. `conflict_err` stays 0 and the second byte of the operation in progress completes.
- R10: Data pushed with any mix of byte and wide pushes comes back in last-in-first-out order from matching pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| wide | input | 1 | 1: the request moves 16 bits as two bytes |
| push_data | input | 16 | Data to push; only bits 7:0 are used for a byte push |
| sp_we | input | 1 | Direct load of the pointer |
| sp_wdata | input | 8 | Value to load into the pointer |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, combinational at `ram_addr` |
| pop_data | output | 16 | Popped value, registered |
| pop_valid | output | 1 | One-cycle strobe: `pop_data` is new |
| busy | output | 1 | Second byte of a wide operation in progress |
| conflict_err | output | 1 | Push and pop requested together |
| sp | output | 8 | Current stack pointer |

## Verification
Two collisions can happen in the same cycle. The first is a pointer load arriving with a push or a pop. The bench provokes it by raising `sp_we` together with a request, and also during the second byte of a wide push. It then checks that nothing is written, that `sp` takes the loaded value, and that the cancelled high byte never reaches RAM. The second collision is a push and a pop requested together, or a new request arriving while `busy` is high. For these the bench checks `conflict_err` and the RAM strobes in that cycle and confirms that `sp` is unchanged or moved only by the operation in progress. A scoreboard queue holds the expected popped values, and later pops confirm that the stack contents survived each collision intact.

// File: rtl/upstack.sv
module upstack #(
  parameter int AW = 8,
  parameter logic [AW-1:0] RESET_SP = 'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic            wide,
  input  logic [2*AW-1:0] push_data,
  input  logic            sp_we,
  input  logic [AW-1:0]   sp_wdata,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_we,
  output logic [AW-1:0]   ram_wdata,
  input  logic [AW-1:0]   ram_rdata,
  output logic [2*AW-1:0] pop_data,
  output logic            pop_valid,
  output logic            busy,
  output logic            conflict_err,
  output logic [AW-1:0]   sp
);

  typedef enum logic [1:0] {IDLE, PUSH_HI, POP_LO} phase_t;

  phase_t        phase;
  logic [AW-1:0] hold;

  wire idle       = (phase == IDLE);
  wire start_push = idle & push_req & ~pop_req & ~sp_we;
  wire start_pop  = idle & pop_req & ~push_req & ~sp_we;
  wire do_read    = start_pop | ((phase == POP_LO) & ~sp_we);

  assign busy         = ~idle;
  assign conflict_err = idle & push_req & pop_req & ~sp_we;
  assign ram_we       = start_push | ((phase == PUSH_HI) & ~sp_we);
  assign ram_addr     = (start_push | (phase == PUSH_HI)) ? sp + 1'b1 : sp;
  assign ram_wdata    = (phase == PUSH_HI) ? hold : push_data[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp        <= RESET_SP;
      phase     <= IDLE;
      hold      <= '0;
      pop_data  <= '0;
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= 1'b0;
      if (sp_we)
        sp <= sp_wdata;
      else if (ram_we)
        sp <= sp + 1'b1;
      else if (do_read)
        sp <= sp - 1'b1;

      if (sp_we)
        phase <= IDLE;
      else if (start_push && wide)
        phase <= PUSH_HI;
      else if (start_pop && wide)
        phase <= POP_LO;
      else
        phase <= IDLE;

      if (start_push && wide)
        hold <= push_data[2*AW-1:AW];
      else if (start_pop && wide)
        hold <= ram_rdata;

      if (start_pop && !wide) begin
        pop_data  <= {{AW{1'b0}}, ram_rdata};
        pop_valid <= 1'b1;
      end else if (phase == POP_LO && !sp_we) begin
        pop_data  <= {hold, ram_rdata};
        pop_valid <= 1'b1;
      end
    end
  end

  // R2
  push_moves_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !sp_we) |=> sp == $past(ram_addr));

  // R3
  pop_steps_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !sp_we && !busy && !wide) |=> (pop_valid && sp == $past(sp) - 1'b1));

  // R7
  conflict_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |-> (!ram_we ##1 (sp == $past(sp) && !pop_valid)));

  // R8
  sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (!ram_we ##1 (sp == $past(sp_wdata) && !busy)));

  // R9
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!conflict_err ##1 !busy));

endmodule

// File: tb/tb_upstack.sv
`timescale 1ns/1ps
module tb_upstack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_req = 0, pop_req = 0, wide = 0, sp_we = 0;
  logic [15:0] push_data = '0;
  logic [7:0]  sp_wdata = '0;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata, sp;
  logic        ram_we, pop_valid, busy, conflict_err;
  logic [15:0] pop_data;

  int checks = 0, errors = 0;
  logic [7:0]  ram [256];
  logic [7:0]  model [256];
  logic [7:0]  msp;
  logic [15:0] expq [$];

  always #10 clk = ~clk;

  upstack dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req), .wide(wide),
    .push_data(push_data), .sp_we(sp_we), .sp_wdata(sp_wdata), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pop_data(pop_data),
    .pop_valid(pop_valid), .busy(busy), .conflict_err(conflict_err), .sp(sp)
  );

  assign ram_rdata = ram[ram_addr];
  always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && pop_valid) begin
      if (expq.size() == 0) chk("R7 unexpected pop_valid", 1, 0);
      else chk("R10 pop_data", pop_data, expq.pop_front());
    end
  end

  task automatic do_push(bit w, logic [15:0] d);
    push_req = 1; wide = w; push_data = d;
    #1;
    chk(w ? "R4 lo we" : "R2 we", ram_we, 1);
    chk(w ? "R4 lo addr" : "R2 addr", ram_addr, 8'(msp + 1));
    chk(w ? "R4 lo data" : "R2 data", ram_wdata, d[7:0]);
    msp = msp + 1; model[msp] = d[7:0];
    @(negedge clk); push_req = 0;
    if (w) begin
      #1;
      chk("R4 busy", busy, 1);
      chk("R4 hi addr", ram_addr, 8'(msp + 1));
      chk("R4 hi data", ram_wdata, d[15:8]);
      msp = msp + 1; model[msp] = d[15:8];
      @(negedge clk);
    end
    chk(w ? "R4 sp" : "R2 sp", sp, msp);
  endtask

  task automatic do_pop(bit w);
    logic [15:0] e;
    pop_req = 1; wide = w;
    #1;
    chk(w ? "R5 hi addr" : "R3 addr", ram_addr, msp);
    chk(w ? "R5 we" : "R3 we", ram_we, 0);
    if (w) begin
      e[15:8] = model[msp]; msp = msp - 1;
      e[7:0] = model[msp]; msp = msp - 1;
    end else begin
      e = {8'h00, model[msp]}; msp = msp - 1;
    end
    expq.push_back(e);
    @(negedge clk); pop_req = 0;
    if (w) begin
      #1;
      chk("R5 busy", busy, 1);
      chk("R5 lo addr", ram_addr, 8'(msp + 1));
      @(negedge clk);
    end
    chk(w ? "R5 sp" : "R3 sp", sp, msp);
  endtask

  task automatic load_sp(logic [7:0] v);
    sp_we = 1; sp_wdata = v;
    @(negedge clk); sp_we = 0;
    msp = v;
    chk("R8 sp load", sp, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 8'(i ^ 8'h5A); model[i] = 8'(i ^ 8'h5A); end
    msp = 8'h07;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sp", sp, 8'h07);
    chk("R1 busy", busy, 0);
    chk("R1 pop_valid", pop_valid, 0);
    chk("R1 we", ram_we, 0);
    chk("R1 pop_data", pop_data, 0);

    do_push(0, 16'h00A1);
    do_push(1, 16'hBEEF);
    do_push(0, 16'h0033);
    do_push(1, 16'h1234);
    do_pop(1);
    do_pop(0);
    do_pop(1);
    do_pop(0);
    chk("R10 sp restored", sp, 8'h07);

    // R7 conflict
    push_req = 1; pop_req = 1; #1;
    chk("R7 err", conflict_err, 1);
    chk("R7 no write", ram_we, 0);
    @(negedge clk); push_req = 0; pop_req = 0;
    chk("R7 sp", sp, msp);
    #3; chk("R7 no pop_valid", pop_valid, 0);

    // R6 wrap
    load_sp(8'hFF);
    do_push(0, 16'h00C7);
    chk("R6 wrap up", sp, 8'h00);
    do_pop(0);
    chk("R6 wrap down", sp, 8'hFF);

    // R8 load with push in same cycle
    load_sp(8'h30);
    push_req = 1; wide = 0; push_data = 16'h0099; sp_we = 1; sp_wdata = 8'h50; #1;
    chk("R8 no write", ram_we, 0);
    @(negedge clk); push_req = 0; sp_we = 0; msp = 8'h50;
    chk("R8 sp", sp, 8'h50);

    // R8 cancel second byte of wide push
    push_req = 1; wide = 1; push_data = 16'h7788;
    @(negedge clk); push_req = 0;
    msp = msp + 1; model[msp] = 8'h88;
    sp_we = 1; sp_wdata = 8'h51; #1;
    chk("R8 cancel hi", ram_we, 0);
    @(negedge clk); sp_we = 0;
    chk("R8 sp cancel", sp, 8'h51);
    chk("R8 not busy", busy, 0);
    do_pop(0);
    chk("R8 high not written", ram[8'h52], model[8'h52]);

    // R9 requests while busy
    push_req = 1; wide = 1; push_data = 16'hCAFE; #1;
    msp = msp + 1; model[msp] = 8'hFE;
    @(negedge clk); push_req = 1; pop_req = 1; wide = 0; #1;
    chk("R9 busy", busy, 1);
    chk("R9 no conflict", conflict_err, 0);
    chk("R9 hi data", ram_wdata, 8'hCA);
    msp = msp + 1; model[msp] = 8'hCA;
    @(negedge clk); push_req = 0; pop_req = 0;
    chk("R9 sp", sp, msp);
    do_pop(1);
    repeat (2) @(negedge clk);
    chk("R10 queue drained", expq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule